// File: doc/BRIEF.md
# Configurable serial frame transmitter

This block turns one parallel character into a serial frame on a single output line. Software, or a neighbouring block, chooses the frame format at run time: 5 to 9 data bits, no parity, even parity or odd parity, and one or two stop bits. Every frame has one low start bit and then the data, least significant bit first. The parity bit, when enabled, comes next. The high stop bits close the frame. The line sits high between frames.

Bit timing comes from one of three sources, chosen by mode inputs:

- **Asynchronous:** an external baud tick advances one bit per tick.
- **Synchronous master:** the block drives a shift clock that toggles on every baud tick.
- **Synchronous slave:** the block follows a shift clock received from outside. That clock passes through a two-flop synchronizer into the system clock domain.

In both synchronous modes, a polarity input picks the shift-clock edge on which the output data changes. Characters enter through a valid/ready handshake. Back-to-back characters produce frames with no idle gap between them.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever `busy` is low, `txd` is high. After reset, `busy` is low and `tx_ready` is high.
- R2: A frame starts with a low start bit. The data bits follow, bit 0 first. The number of data bits is set by `data_len`: code 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8 and 4 gives 9. Codes 5 to 7 also give 9.
- R3: `par_mode` selects the parity: 2'b00 or 2'b01 gives no parity bit, 2'b10 gives even parity, 2'b11 gives odd parity. Even parity is the XOR of the configured data bits, and odd parity is its inverse. The parity bit is sent directly after the last data bit.
- R4: The frame ends with one high stop bit when `two_stop` is 0, and with two high stop bits when it is 1.
- R5: A character is taken on a clock edge where `tx_valid` and `tx_ready` are both high, and `tx_ready` equals the inverse of `busy`. `busy` rises on the edge after acceptance. It stays high until the edge that places the final stop bit on the line.
- R6: A character offered while the final stop bit is on the line is accepted. Its start bit directly follows that stop bit, with no idle time between them.
- R7: When `sync_en` is 0, each bit holds for one baud-tick interval. `txd` changes only on the clock edge at which `baud_tick` is high.
- R8: When `sync_en` and `master` are both 1:
  - `sck_oe` is high and `sck_o` toggles on every `baud_tick`.
  - With `clk_pol` 0, `txd` changes together with a rising `sck_o`.
  - With `clk_pol` 1, `txd` changes together with a falling `sck_o`.
- R9: When `sync_en` is 1 and `master` is 0:
  - `sck_oe` is low.
  - `txd` changes on the third rising system clock edge after a change edge of `sck_i`.
  - The change edge is a rising `sck_i` when `clk_pol` is 0, and a falling `sck_i` when `clk_pol` is 1.
- R10: Bits of `tx_data` at or above the configured width are neither transmitted nor counted in the parity.
- R11: The format inputs are captured at acceptance, so changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle bit-rate strobe |
| sync_en | input | 1 | 1 selects synchronous mode |
| master | input | 1 | In synchronous mode, 1 makes the block drive the shift clock |
| clk_pol | input | 1 | Shift-clock polarity: 0 changes data on the rising edge, 1 on the falling edge |
| data_len | input | 3 | Data width code (0 to 4 select 5 to 9 bits) |
| par_mode | input | 2 | Parity select |
| two_stop | input | 1 | 1 selects two stop bits |
| tx_data | input | 9 | Character to send |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Block can accept a character |
| txd | output | 1 | Serial data line |
| busy | output | 1 | A frame is still being placed on the line |
| sck_i | input | 1 | Shift clock received in slave mode |
| sck_o | output | 1 | Shift clock driven in master mode |
| sck_oe | output | 1 | Output enable for the shift-clock pad |

## Verification
The checker watches several relations on every cycle:
- the idle level of the line;
- the low start bit that follows each acceptance;
- the high final stop bit when `busy` falls;
- the handshake relation;
- the rule that `txd` moves only on a bit strobe;
- in master mode, the match between data changes and the polarity-selected shift-clock edge.

Other properties can only be shown by the bench's scenarios, where a reference model predicts the line cycle by cycle and is compared with it:
- the exact bit order of all 30 formats;
- the parity values and the masking of unused data bits;
- the zero-gap chaining of frames;
- the synchronizer latency in slave mode.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

  typedef enum logic [1:0] {
    PAR_OFF     = 2'b00,
    PAR_OFF_ALT = 2'b01,
    PAR_EVEN    = 2'b10,
    PAR_ODD     = 2'b11
  } par_mode_e;

  function automatic logic par_enabled(input par_mode_e pm);
    return (pm == PAR_EVEN) || (pm == PAR_ODD);
  endfunction

endpackage

// File: rtl/sftx_step_gen.sv
module sftx_step_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic baud_tick,
  input  logic sync_en,
  input  logic master,
  input  logic clk_pol,
  input  logic sck_i,
  output logic step,
  output logic sck_o
);

  logic [SYNC_STAGES:0] chain;
  logic                 sck_q;
  logic                 ext_rise;
  logic                 ext_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      sck_q <= 1'b0;
    end else begin
      chain <= {chain[SYNC_STAGES-1:0], sck_i};
      if (sync_en && master && baud_tick) begin
        sck_q <= ~sck_q;
      end
    end
  end

  assign ext_rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
  assign ext_fall = ~chain[SYNC_STAGES-1] & chain[SYNC_STAGES];

  always_comb begin
    if (!sync_en) begin
      step = baud_tick;
    end else if (master) begin
      step = baud_tick & (sck_q == clk_pol);
    end else begin
      step = clk_pol ? ext_fall : ext_rise;
    end
  end

  assign sck_o = sck_q;

endmodule

// File: rtl/sftx_frame_build.sv
module sftx_frame_build
  import sftx_pkg::*;
#(
  parameter int DATA_MAX  = 9,
  parameter int DATA_MIN  = 5,
  parameter int FRAME_MAX = DATA_MAX + 4,
  parameter int LEN_W     = $clog2(FRAME_MAX + 1),
  parameter int CODE_W    = $clog2(DATA_MAX - DATA_MIN + 1)
) (
  input  logic [DATA_MAX-1:0]  data,
  input  logic [CODE_W-1:0]    len_code,
  input  logic [1:0]           par_mode,
  input  logic                 two_stop,
  output logic [FRAME_MAX-1:0] frame_vec,
  output logic [LEN_W-1:0]     frame_len
);

  localparam int MAX_CODE = DATA_MAX - DATA_MIN;

  par_mode_e         pm;
  logic [CODE_W-1:0] code_cap;
  logic              par_bit;
  logic              par_on;
  int                nbits;

  always_comb begin
    pm       = par_mode_e'(par_mode);
    par_on   = par_enabled(pm);
    code_cap = (int'(len_code) > MAX_CODE) ? CODE_W'(MAX_CODE) : len_code;
    nbits    = DATA_MIN + int'(code_cap);
    par_bit  = (pm == PAR_ODD);
    frame_vec    = '1;
    frame_vec[0] = 1'b0;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < nbits) begin
        frame_vec[1+i] = data[i];
        par_bit        = par_bit ^ data[i];
      end
    end
    if (par_on) begin
      frame_vec[1+nbits] = par_bit;
    end
    frame_len = LEN_W'(2 + nbits + (par_on ? 1 : 0) + (two_stop ? 1 : 0));
  end

endmodule

// File: rtl/sftx_shifter.sv
module sftx_shifter #(
  parameter int FRAME_MAX = 13,
  parameter int LEN_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [FRAME_MAX-1:0] frame_vec,
  input  logic [LEN_W-1:0]     frame_len,
  input  logic                 step,
  output logic                 txd,
  output logic                 busy
);

  logic [FRAME_MAX-1:0] sr;
  logic [LEN_W-1:0]     left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '1;
      left <= '0;
      txd  <= 1'b1;
    end else if (load) begin
      sr   <= frame_vec;
      left <= frame_len;
    end else if (step && (left != '0)) begin
      txd  <= sr[0];
      sr   <= {1'b1, sr[FRAME_MAX-1:1]};
      left <= left - 1'b1;
    end
  end

  assign busy = (left != '0);

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int DATA_MAX    = 9,
  parameter int DATA_MIN    = 5,
  parameter int SYNC_STAGES = 2,
  parameter int CODE_W      = $clog2(DATA_MAX - DATA_MIN + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                baud_tick,
  input  logic                sync_en,
  input  logic                master,
  input  logic                clk_pol,
  input  logic [CODE_W-1:0]   data_len,
  input  logic [1:0]          par_mode,
  input  logic                two_stop,
  input  logic [DATA_MAX-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic                txd,
  output logic                busy,
  input  logic                sck_i,
  output logic                sck_o,
  output logic                sck_oe
);

  localparam int FRAME_MAX = DATA_MAX + 4;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);

  logic [FRAME_MAX-1:0] frame_vec;
  logic [LEN_W-1:0]     frame_len;
  logic                 step_w;
  logic                 load;

  sftx_step_gen #(.SYNC_STAGES(SYNC_STAGES)) u_step (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .sync_en(sync_en),
    .master(master), .clk_pol(clk_pol), .sck_i(sck_i),
    .step(step_w), .sck_o(sck_o)
  );

  sftx_frame_build #(
    .DATA_MAX(DATA_MAX), .DATA_MIN(DATA_MIN), .FRAME_MAX(FRAME_MAX),
    .LEN_W(LEN_W), .CODE_W(CODE_W)
  ) u_build (
    .data(tx_data), .len_code(data_len), .par_mode(par_mode),
    .two_stop(two_stop), .frame_vec(frame_vec), .frame_len(frame_len)
  );

  sftx_shifter #(.FRAME_MAX(FRAME_MAX), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .frame_vec(frame_vec),
    .frame_len(frame_len), .step(step_w), .txd(txd), .busy(busy)
  );

  assign tx_ready = ~busy;
  assign load     = tx_valid & tx_ready;
  assign sck_oe   = sync_en & master;

endmodule

// File: rtl/sftx_checker.sv
module sftx_checker (
  input logic clk,
  input logic rst,
  input logic step_w,
  input logic busy,
  input logic txd,
  input logic tx_valid,
  input logic tx_ready,
  input logic sync_en,
  input logic master,
  input logic clk_pol,
  input logic sck_o
);

  logic first_pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_pending <= 1'b0;
    end else if (tx_valid && tx_ready) begin
      first_pending <= 1'b1;
    end else if (step_w) begin
      first_pending <= 1'b0;
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd); // R1

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    (step_w && first_pending && !(tx_valid && tx_ready)) |=> !txd); // R2

  AST_LAST_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> txd); // R4

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> busy); // R5

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && !step_w) |=> busy); // R5

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step_w |=> $stable(txd)); // R7

  AST_MASTER_EDGE: assert property (@(posedge clk) disable iff (rst)
    ($past(sync_en) && $past(master) && (txd != $past(txd)))
      |-> (sck_o == ~$past(clk_pol))); // R8

endmodule

bind serial_frame_tx sftx_checker u_chk (
  .clk(clk), .rst(rst), .step_w(step_w), .busy(busy), .txd(txd),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .sync_en(sync_en),
  .master(master), .clk_pol(clk_pol), .sck_o(sck_o)
);

// File: tb/sim_serial_frame_tx.sv
module sim_serial_frame_tx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       sync_en = 1'b0;
  logic       master = 1'b0;
  logic       clk_pol = 1'b0;
  logic [2:0] data_len = 3'd3;
  logic [1:0] par_mode = 2'b00;
  logic       two_stop = 1'b0;
  logic [8:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready, txd, busy, sck_o, sck_oe;
  logic       sck_i = 1'b0;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done = 0;
  bit    compare_on = 0;
  bit    slave_run = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  serial_frame_tx u0 (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .sync_en(sync_en),
    .master(master), .clk_pol(clk_pol), .data_len(data_len),
    .par_mode(par_mode), .two_stop(two_stop), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd), .busy(busy),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe)
  );

  // baud strobe: one cycle in four
  int bdiv = 0;
  always @(negedge clk) begin
    bdiv      = (bdiv == 3) ? 0 : bdiv + 1;
    baud_tick = (bdiv == 3);
  end

  // external shift clock for slave mode, half period 6 cycles
  int sdiv = 0;
  always @(negedge clk) begin
    if (slave_run) begin
      sdiv = sdiv + 1;
      if (sdiv == 6) begin
        sdiv  = 0;
        sck_i = ~sck_i;
      end
    end
  end

  // reference model
  bit m_q[$];
  bit m_txd = 1;
  bit m_sck = 0;
  bit h1 = 0, h2 = 0, h3 = 0;

  always @(posedge clk) begin
    bit stp;
    bit empty;
    int w;
    bit p;
    if (rst) begin
      m_q.delete();
      m_txd = 1; m_sck = 0; h1 = 0; h2 = 0; h3 = 0;
    end else begin
      if (!sync_en)    stp = baud_tick;
      else if (master) stp = baud_tick && (m_sck == clk_pol);
      else             stp = clk_pol ? (!h2 && h3) : (h2 && !h3);
      empty = (m_q.size() == 0);
      if (stp && !empty) m_txd = m_q.pop_front();
      if (tx_valid && empty) begin
        w = (data_len > 3'd4) ? 9 : 5 + int'(data_len);
        p = (par_mode == 2'b11);
        m_q.push_back(1'b0);
        for (int i = 0; i < w; i++) begin
          m_q.push_back(tx_data[i]);
          p = p ^ tx_data[i];
        end
        if (par_mode[1]) m_q.push_back(p);
        m_q.push_back(1'b1);
        if (two_stop) m_q.push_back(1'b1);
      end
      if (sync_en && master && baud_tick) m_sck = !m_sck;
      h3 = h2; h2 = h1; h1 = sck_i;
    end
  end

  task automatic check(input string req, input string sig, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, sig, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (compare_on) begin
      check(cur_req, "txd", txd, m_txd);
      check("R5", "busy", busy, m_q.size() != 0);
      check("R5", "tx_ready", tx_ready, m_q.size() == 0);
      check("R8", "sck_o", sck_o, m_sck);
      check("R9", "sck_oe", sck_oe, sync_en && master);
    end
  end

  task automatic send(input logic [8:0] d);
    tx_data  = d;
    tx_valid = 1'b1;
    while (1) begin
      if (tx_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    tx_valid = 1'b0;
  endtask

  task automatic drain();
    while (busy) @(negedge clk);
    repeat (60) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", "txd_reset", txd, 1'b1);
    check("R1", "busy_reset", busy, 1'b0);
    check("R1", "ready_reset", tx_ready, 1'b1);
    compare_on = 1;

    // R7 R2: asynchronous 8N1
    cur_req = "R2_R7";
    data_len = 3'd3; par_mode = 2'b00; two_stop = 0;
    send(9'h0A5);
    send(9'h03C);
    drain();

    // all 30 formats back to back (R2 R3 R4 R6)
    cur_req = "R2_R3_R4_R6";
    for (int c = 0; c < 5; c++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int s = 0; s < 2; s++) begin
          data_len = 3'(c);
          par_mode = (pm == 0) ? 2'b00 : ((pm == 1) ? 2'b10 : 2'b11);
          two_stop = s[0];
          send(9'((c * 97 + pm * 41 + s * 13 + 5) & 9'h1FF));
        end
      end
    end
    drain();

    // R10 R2: upper bits ignored, oversize codes give 9 bits
    cur_req = "R10_R2";
    data_len = 3'd0; par_mode = 2'b10; two_stop = 0;
    send(9'h1E0);
    send(9'h1F5);
    data_len = 3'd7; par_mode = 2'b11;
    send(9'h155);
    // R11: format changed right after acceptance
    cur_req = "R11";
    data_len = 3'd1; par_mode = 2'b10; two_stop = 1;
    send(9'h0F3);
    data_len = 3'd4; par_mode = 2'b00; two_stop = 0;
    drain();

    // R8: synchronous master, both polarities
    cur_req = "R8";
    sync_en = 1; master = 1; clk_pol = 0;
    data_len = 3'd3; par_mode = 2'b10; two_stop = 0;
    send(9'h0C9);
    send(9'h012);
    drain();
    clk_pol = 1;
    send(9'h06E);
    send(9'h1B1);
    drain();

    // R9: synchronous slave, both polarities
    cur_req = "R9";
    master = 0; clk_pol = 0; slave_run = 1;
    send(9'h0A3);
    send(9'h05C);
    drain();
    clk_pol = 1;
    two_stop = 1; par_mode = 2'b11;
    send(9'h1C7);
    drain();
    slave_run = 0;

    compare_on = 0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule